// File: doc/BRIEF.md
# ATM Receive Per-Channel Packet Tracker

This block keeps the receive context of each virtual channel for the reassembly side of an ATM adapter. Each arriving cell brings a channel number, its 3-bit payload-type field and a valid strobe. The cell data itself is handled elsewhere. The block tracks only the packet state of each channel: whether the channel is active, the congestion-marked cell count, the byte length, and a start pointer and a current pointer into the host buffer.

Each channel has a static control field, written through a configuration port. When the first cell of a packet arrives on an inactive channel, the block asks a free-buffer source for a buffer of the channel's size class. When the grant arrives, the static control field is copied into the dynamic context with the active bit set, and both pointers are loaded from the granted address. On the last cell, a completion record is presented to a sink. The channel returns to inactive when the sink takes the record.

A three-state machine drives the flow. ST_IDLE accepts cells. ST_FETCH holds a buffer request. ST_POST holds a completion record. The transitions are:
- IDLE to FETCH: first cell on an inactive enabled channel.
- IDLE to POST: last cell on an active channel.
- FETCH to IDLE: grant for a cell that is not last.
- FETCH to POST: grant for a single-cell packet.
- POST to IDLE: the sink accepts the record.

Top module: `atm_rx_vc_tracker`

## Requirements
- R1: While rst_n is low at a clock edge, every channel becomes inactive and every static control field is cleared. After that edge, cell_ready is 1, buf_req is 0 and cmp_valid is 0.
- R2: A cell on an inactive channel whose static field has bit 7 set (channel on) raises exactly one buffer request. buf_size_big equals static bit 6. Later cells of the same packet raise no request.
- R3: From the cycle buf_req rises until the cycle buf_gnt is seen, buf_req stays 1, buf_size_big stays stable and cell_ready stays 0.
- R4: A cell on an inactive channel whose static bit 7 is clear is consumed. It raises no request and produces no completion.
- R5: Each accepted cell of a packet adds 48 to its length. The length saturates at 2047.
- R6: A cell whose payload type is 010 or 011 increments the congestion count. The count saturates at 2047 and starts at zero for each packet.
- R7: A packet ends on a cell whose payload type is 001 or 011, but only when static bit 5 (null mode) and bit 2 (segment mode) were both clear at packet start. In either other mode, the payload type never ends a packet.
- R8: The completion record carries four values:
  - the channel number;
  - the final congestion count and length;
  - the granted address as start pointer;
  - the start pointer plus 48 per cell, modulo 2^28, as current pointer.
- R9: The record is held stable with cmp_valid high until cmp_ready. During that time cell_ready is 0. When the record is accepted, the channel becomes inactive, so its next cell requests a new buffer.
- R10: For a single-cell packet, activation and completion happen on the same grant edge. The record has length 48 and the granted start address.
- R11: A static field written while a packet is open takes effect only at the next packet start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Static control write strobe |
| cfg_ch | input | 4 | Channel whose static field is written |
| cfg_ctrl | input | 9 | Static field: bit 7 on, bit 6 big buffers, bit 5 null mode, bit 2 segment mode, bits 1:0 end wait |
| cell_valid | input | 1 | Cell header present |
| cell_ready | output | 1 | Cell accepted on this edge when valid |
| cell_ch | input | 4 | Channel number of the cell |
| cell_pti | input | 3 | Payload-type field of the cell |
| buf_req | output | 1 | Buffer request pending |
| buf_size_big | output | 1 | Size class of the requested buffer |
| buf_gnt | input | 1 | Buffer source grants this cycle |
| buf_addr | input | 28 | Granted buffer address |
| cmp_valid | output | 1 | Completion record present |
| cmp_ready | input | 1 | Sink takes the record |
| cmp_ch | output | 4 | Channel of the finished packet |
| cmp_efc | output | 11 | Congestion-marked cell count |
| cmp_len | output | 11 | Packet length in bytes |
| cmp_start | output | 28 | Start-of-buffer pointer |
| cmp_cur | output | 28 | Final current-buffer pointer |

## Verification
Activation and completion can land on the same edge: a single-cell packet is granted its buffer in ST_FETCH, and that grant also ends the packet. The bench provokes this with a lone 011 cell and a repeat lone cell on the same channel. It judges the record's start and length against the granted address, checks that the count includes the one marked cell, and checks that the repeat cell requests a fresh buffer. A second overlap puts a static-field write inside an open packet. The packet must still finish under the old copy, and the next packet must follow the new field.

// File: rtl/atm_rx_pkg.sv
package atm_rx_pkg;

    localparam int CTRL_W = 9;
    localparam int CNT_W  = 11;
    localparam int PTR_W  = 28;

    // control field bit positions
    localparam int B_OWN   = 8;
    localparam int B_CHON  = 7;
    localparam int B_BIG   = 6;
    localparam int B_NULL  = 5;
    localparam int B_AAL34 = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_POST  = 2'd2
    } trk_state_e;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [CNT_W-1:0]  efc;
        logic [CNT_W-1:0]  len;
        logic [PTR_W-1:0]  cur;
        logic [PTR_W-1:0]  start;
    } vc_ctx_t;

endpackage

// File: rtl/atm_rx_ctx_table.sv
module atm_rx_ctx_table
    import atm_rx_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CH_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [CTRL_W-1:0] cfg_ctrl,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [CTRL_W-1:0] rd_static,
    output vc_ctx_t           rd_ctx,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  vc_ctx_t           wr_ctx
);

    logic [CTRL_W-1:0] static_q [NUM_CH];
    vc_ctx_t           dyn_q    [NUM_CH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                static_q[i] <= '0;
                dyn_q[i]    <= '0;
            end
        end else begin
            if (cfg_we) static_q[cfg_ch] <= cfg_ctrl;
            if (wr_en)  dyn_q[wr_ch]     <= wr_ctx;
        end
    end

    assign rd_static = static_q[rd_ch];
    assign rd_ctx    = dyn_q[rd_ch];

endmodule

// File: rtl/atm_rx_cell_step.sv
module atm_rx_cell_step
    import atm_rx_pkg::*;
#(
    parameter int CELL_BYTES = 48
) (
    input  vc_ctx_t           ctx_in,
    input  logic              activate,
    input  logic [CTRL_W-1:0] start_ctrl,
    input  logic [PTR_W-1:0]  base_addr,
    input  logic [2:0]        pti,
    output vc_ctx_t           ctx_out,
    output logic              last
);

    localparam logic [CNT_W-1:0] LEN_MAX  = '1;
    localparam logic [CNT_W-1:0] LEN_STEP = CNT_W'(CELL_BYTES);
    localparam logic [PTR_W-1:0] PTR_STEP = PTR_W'(CELL_BYTES);

    vc_ctx_t base;

    always_comb begin
        if (activate) begin
            base.ctrl        = start_ctrl;
            base.ctrl[B_OWN] = 1'b1;
            base.efc         = '0;
            base.len         = '0;
            base.cur         = base_addr;
            base.start       = base_addr;
        end else begin
            base = ctx_in;
        end
    end

    always_comb begin
        ctx_out       = base;
        if (pti[2:1] == 2'b01 && base.efc != LEN_MAX)
            ctx_out.efc = base.efc + 1'b1;
        ctx_out.len   = (base.len > LEN_MAX - LEN_STEP) ? LEN_MAX : base.len + LEN_STEP;
        ctx_out.cur   = base.cur + PTR_STEP;
        last          = !base.ctrl[B_NULL] && !base.ctrl[B_AAL34] && !pti[2] && pti[0];
    end

endmodule

// File: rtl/atm_rx_vc_tracker.sv
module atm_rx_vc_tracker
    import atm_rx_pkg::*;
#(
    parameter int NUM_CH     = 16,
    parameter int CELL_BYTES = 48,
    localparam int CH_W      = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [CTRL_W-1:0] cfg_ctrl,
    input  logic              cell_valid,
    output logic              cell_ready,
    input  logic [CH_W-1:0]   cell_ch,
    input  logic [2:0]        cell_pti,
    output logic              buf_req,
    output logic              buf_size_big,
    input  logic              buf_gnt,
    input  logic [PTR_W-1:0]  buf_addr,
    output logic              cmp_valid,
    input  logic              cmp_ready,
    output logic [CH_W-1:0]   cmp_ch,
    output logic [CNT_W-1:0]  cmp_efc,
    output logic [CNT_W-1:0]  cmp_len,
    output logic [PTR_W-1:0]  cmp_start,
    output logic [PTR_W-1:0]  cmp_cur
);

    trk_state_e state_q, state_d;

    logic [CH_W-1:0]   pend_ch_q;
    logic [2:0]        pend_pti_q;
    logic [CTRL_W-1:0] pend_ctrl_q;

    logic [CH_W-1:0]   rec_ch_q;
    logic [CNT_W-1:0]  rec_efc_q, rec_len_q;
    logic [PTR_W-1:0]  rec_start_q, rec_cur_q;

    logic [CH_W-1:0]   rd_ch, wr_ch, rec_src_ch;
    logic [CTRL_W-1:0] rd_static;
    vc_ctx_t           rd_ctx, wr_ctx, step_ctx;
    logic              wr_en, step_last, load_pend, load_rec;

    always_comb begin
        unique case (state_q)
            ST_FETCH: rd_ch = pend_ch_q;
            ST_POST:  rd_ch = rec_ch_q;
            default:  rd_ch = cell_ch;
        endcase
    end

    atm_rx_ctx_table #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_ch    (cfg_ch),
        .cfg_ctrl  (cfg_ctrl),
        .rd_ch     (rd_ch),
        .rd_static (rd_static),
        .rd_ctx    (rd_ctx),
        .wr_en     (wr_en),
        .wr_ch     (wr_ch),
        .wr_ctx    (wr_ctx)
    );

    atm_rx_cell_step #(
        .CELL_BYTES (CELL_BYTES)
    ) u_step (
        .ctx_in     (rd_ctx),
        .activate   (state_q == ST_FETCH),
        .start_ctrl (pend_ctrl_q),
        .base_addr  (buf_addr),
        .pti        ((state_q == ST_FETCH) ? pend_pti_q : cell_pti),
        .ctx_out    (step_ctx),
        .last       (step_last)
    );

    // next state and context write control
    always_comb begin
        state_d    = state_q;
        wr_en      = 1'b0;
        wr_ch      = cell_ch;
        wr_ctx     = step_ctx;
        load_pend  = 1'b0;
        load_rec   = 1'b0;
        rec_src_ch = cell_ch;
        unique case (state_q)
            ST_IDLE: begin
                if (cell_valid) begin
                    if (rd_ctx.ctrl[B_OWN]) begin
                        wr_en = 1'b1;
                        if (step_last) begin
                            load_rec = 1'b1;
                            state_d  = ST_POST;
                        end
                    end else if (rd_static[B_CHON]) begin
                        load_pend = 1'b1;
                        state_d   = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                wr_ch      = pend_ch_q;
                rec_src_ch = pend_ch_q;
                if (buf_gnt) begin
                    wr_en = 1'b1;
                    if (step_last) begin
                        load_rec = 1'b1;
                        state_d  = ST_POST;
                    end else begin
                        state_d  = ST_IDLE;
                    end
                end
            end
            ST_POST: begin
                wr_ch             = rec_ch_q;
                wr_ctx            = rd_ctx;
                wr_ctx.ctrl[B_OWN] = 1'b0;
                if (cmp_ready) begin
                    wr_en   = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            pend_ch_q   <= '0;
            pend_pti_q  <= '0;
            pend_ctrl_q <= '0;
            rec_ch_q    <= '0;
            rec_efc_q   <= '0;
            rec_len_q   <= '0;
            rec_start_q <= '0;
            rec_cur_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load_pend) begin
                pend_ch_q   <= cell_ch;
                pend_pti_q  <= cell_pti;
                pend_ctrl_q <= rd_static;
            end
            if (load_rec) begin
                rec_ch_q    <= rec_src_ch;
                rec_efc_q   <= step_ctx.efc;
                rec_len_q   <= step_ctx.len;
                rec_start_q <= step_ctx.start;
                rec_cur_q   <= step_ctx.cur;
            end
        end
    end

    always_comb begin
        cell_ready   = (state_q == ST_IDLE);
        buf_req      = (state_q == ST_FETCH);
        buf_size_big = pend_ctrl_q[B_BIG];
        cmp_valid    = (state_q == ST_POST);
        cmp_ch       = rec_ch_q;
        cmp_efc      = rec_efc_q;
        cmp_len      = rec_len_q;
        cmp_start    = rec_start_q;
        cmp_cur      = rec_cur_q;
    end

endmodule

// File: rtl/atm_rx_vc_tracker_chk.sv
module atm_rx_vc_tracker_chk
    import atm_rx_pkg::*;
#(
    parameter int CH_W       = 4,
    parameter int CELL_BYTES = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cell_ready,
    input logic             buf_req,
    input logic             buf_size_big,
    input logic             buf_gnt,
    input logic             cmp_valid,
    input logic             cmp_ready,
    input logic [CH_W-1:0]  cmp_ch,
    input logic [CNT_W-1:0] cmp_efc,
    input logic [CNT_W-1:0] cmp_len,
    input logic [PTR_W-1:0] cmp_start,
    input logic [PTR_W-1:0] cmp_cur
);

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> cell_ready && !buf_req && !cmp_valid);

    a_r3_req_blocks_cells: assert property (@(posedge clk) disable iff (!rst_n)
        buf_req |-> !cell_ready);

    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        buf_req && !buf_gnt |=> buf_req && $stable(buf_size_big));

    a_r2_grant_ends_req: assert property (@(posedge clk) disable iff (!rst_n)
        buf_req && buf_gnt |=> !buf_req);

    a_r9_cmp_held: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid && !cmp_ready |=> cmp_valid && $stable(cmp_ch) && $stable(cmp_efc)
            && $stable(cmp_len) && $stable(cmp_start) && $stable(cmp_cur));

    a_r9_cmp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> !cell_ready && !buf_req);

    a_r5_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> cmp_len >= CNT_W'(CELL_BYTES) && cmp_efc <= cmp_len);

endmodule

bind atm_rx_vc_tracker atm_rx_vc_tracker_chk #(
    .CH_W       (CH_W),
    .CELL_BYTES (CELL_BYTES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cell_ready   (cell_ready),
    .buf_req      (buf_req),
    .buf_size_big (buf_size_big),
    .buf_gnt      (buf_gnt),
    .cmp_valid    (cmp_valid),
    .cmp_ready    (cmp_ready),
    .cmp_ch       (cmp_ch),
    .cmp_efc      (cmp_efc),
    .cmp_len      (cmp_len),
    .cmp_start    (cmp_start),
    .cmp_cur      (cmp_cur)
);

// File: tb/atm_rx_vc_tracker_bench.sv
`timescale 1ns/1ps
module atm_rx_vc_tracker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_ch = '0;
    logic [8:0]  cfg_ctrl = '0;
    logic        cell_valid = 1'b0;
    logic        cell_ready;
    logic [3:0]  cell_ch = '0;
    logic [2:0]  cell_pti = '0;
    logic        buf_req, buf_size_big;
    logic        buf_gnt = 1'b0;
    logic [27:0] buf_addr = '0;
    logic        cmp_valid;
    logic        cmp_ready = 1'b1;
    logic [3:0]  cmp_ch;
    logic [10:0] cmp_efc, cmp_len;
    logic [27:0] cmp_start, cmp_cur;

    atm_rx_vc_tracker u_atm_rx_vc_tracker (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_ctrl(cfg_ctrl),
        .cell_valid(cell_valid), .cell_ready(cell_ready), .cell_ch(cell_ch), .cell_pti(cell_pti),
        .buf_req(buf_req), .buf_size_big(buf_size_big), .buf_gnt(buf_gnt), .buf_addr(buf_addr),
        .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_ch(cmp_ch), .cmp_efc(cmp_efc),
        .cmp_len(cmp_len), .cmp_start(cmp_start), .cmp_cur(cmp_cur)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_err = 0, req_cnt = 0, cmp_cnt = 0;
    logic        gnt_en = 1'b1;
    logic        last_big = 1'b0;
    logic [27:0] next_addr = '0;
    logic [3:0]  cap_ch;
    logic [10:0] cap_efc, cap_len;
    logic [27:0] cap_start, cap_cur;
    bit          finished = 0;

    // packet vectors: {ch, cells, marked cells, buffer address}
    localparam int NVEC = 6;
    localparam logic [47:0] VEC [NVEC] = '{
        {4'd0, 8'd2,  8'd1,  28'h0001000},
        {4'd1, 8'd5,  8'd0,  28'h0ABCDE0},
        {4'd0, 8'd3,  8'd3,  28'h0002000},
        {4'd2, 8'd1,  8'd1,  28'h0003000},
        {4'd3, 8'd43, 8'd10, 28'hFFFFFF0},
        {4'd1, 8'd4,  8'd2,  28'h0100000}
    };

    // buffer source model
    initial forever begin
        @(negedge clk);
        if (buf_req && gnt_en) begin
            buf_gnt  = 1'b1;
            buf_addr = next_addr;
            last_big = buf_size_big;
            req_cnt++;
        end else begin
            buf_gnt = 1'b0;
        end
    end

    // completion sink monitor
    initial forever begin
        @(negedge clk);
        if (cmp_valid && cmp_ready) begin
            cap_ch = cmp_ch; cap_efc = cmp_efc; cap_len = cmp_len;
            cap_start = cmp_start; cap_cur = cmp_cur;
            cmp_cnt++;
        end
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send_cell(input logic [3:0] ch, input logic [2:0] pti);
        @(negedge clk);
        cell_valid = 1'b1; cell_ch = ch; cell_pti = pti;
        while (!cell_ready) @(negedge clk);
        @(negedge clk);
        cell_valid = 1'b0;
    endtask

    task automatic send_pkt(input logic [3:0] ch, input int n, input int nm);
        for (int i = 0; i < n; i++)
            send_cell(ch, {1'b0, (i < nm), (i == n - 1)});
    endtask

    task automatic cfg(input logic [3:0] ch, input logic [8:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = ch; cfg_ctrl = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_cmp(input int target, output bit got);
        got = 0;
        for (int i = 0; i < 60; i++) begin
            if (cmp_cnt >= target) begin got = 1; return; end
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        bit got;
        int r0, c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cell_ready == 1'b1, "R1", "cell_ready after reset", 32'(cell_ready), 1);
        chk(buf_req == 1'b0,    "R1", "buf_req after reset", 32'(buf_req), 0);
        chk(cmp_valid == 1'b0,  "R1", "cmp_valid after reset", 32'(cmp_valid), 0);

        cfg(4'd0, 9'h080); cfg(4'd1, 9'h0C0); cfg(4'd2, 9'h080); cfg(4'd3, 9'h080);
        cfg(4'd4, 9'h084); cfg(4'd5, 9'h000); cfg(4'd6, 9'h080); cfg(4'd7, 9'h080);

        // vector walk
        for (int e = 0; e < NVEC; e++) begin
            logic [3:0]  ch;
            int          n, nm;
            logic [27:0] a;
            logic [10:0] elen;
            ch = VEC[e][47:44]; n = int'(VEC[e][43:36]); nm = int'(VEC[e][35:28]); a = VEC[e][27:0];
            elen = (n * 48 > 2047) ? 11'd2047 : 11'(n * 48);
            r0 = req_cnt; c0 = cmp_cnt; next_addr = a;
            send_pkt(ch, n, nm);
            wait_cmp(c0 + 1, got);
            chk(got, "R7", "packet ended on 0x1 cell", 32'(got), 1);
            chk(req_cnt - r0 == 1, "R2", "one request per packet", 32'(req_cnt - r0), 1);
            chk(last_big == (ch == 4'd1), "R2", "size class", 32'(last_big), 32'(ch == 4'd1));
            chk(cap_ch == ch, "R8", "record channel", 32'(cap_ch), 32'(ch));
            chk(cap_len == elen, "R5", "record length", 32'(cap_len), 32'(elen));
            chk(cap_efc == 11'(nm), "R6", "congestion count", 32'(cap_efc), 32'(nm));
            chk(cap_start == a, "R8", "start pointer", 32'(cap_start), 32'(a));
            chk(cap_cur == 28'(a + 28'(48 * n)), "R8", "current pointer",
                32'(cap_cur), 32'(28'(a + 28'(48 * n))));
        end

        // R10: repeat single-cell packet on same channel, grant and completion together
        r0 = req_cnt; c0 = cmp_cnt; next_addr = 28'h0777770;
        send_cell(4'd2, 3'b011);
        wait_cmp(c0 + 1, got);
        chk(got && req_cnt - r0 == 1, "R10", "single cell new buffer", 32'(req_cnt - r0), 1);
        chk(cap_start == 28'h0777770, "R10", "single cell start", 32'(cap_start), 32'h0777770);
        chk(cap_len == 11'd48, "R10", "single cell length", 32'(cap_len), 48);
        chk(cap_efc == 11'd1, "R10", "single cell count", 32'(cap_efc), 1);

        // R3: request held while no grant
        gnt_en = 1'b0; next_addr = 28'h0200000; r0 = req_cnt; c0 = cmp_cnt;
        send_cell(4'd1, 3'b000);
        for (int i = 0; i < 4; i++) begin
            chk(buf_req == 1'b1, "R3", "request held", 32'(buf_req), 1);
            chk(cell_ready == 1'b0, "R3", "cells blocked", 32'(cell_ready), 0);
            chk(buf_size_big == 1'b1, "R3", "size stable", 32'(buf_size_big), 1);
            @(negedge clk);
        end
        @(posedge clk); #1 gnt_en = 1'b1;
        send_cell(4'd1, 3'b001);
        wait_cmp(c0 + 1, got);
        chk(got && cap_len == 11'd96, "R3", "packet after late grant", 32'(cap_len), 96);

        // R9: sink back-pressure
        @(posedge clk); #1 cmp_ready = 1'b0;
        next_addr = 28'h0300000; c0 = cmp_cnt;
        send_pkt(4'd0, 2, 0);
        for (int i = 0; i < 5; i++) begin
            chk(cmp_valid == 1'b1, "R9", "record held", 32'(cmp_valid), 1);
            chk(cell_ready == 1'b0, "R9", "cells blocked while posting", 32'(cell_ready), 0);
            chk(cmp_len == 11'd96, "R9", "record stable", 32'(cmp_len), 96);
            @(negedge clk);
        end
        @(posedge clk); #1 cmp_ready = 1'b1;
        wait_cmp(c0 + 1, got);
        chk(got, "R9", "record taken", 32'(got), 1);
        r0 = req_cnt; c0 = cmp_cnt;
        send_pkt(4'd0, 1, 0);
        wait_cmp(c0 + 1, got);
        chk(req_cnt - r0 == 1, "R9", "inactive after accept", 32'(req_cnt - r0), 1);

        // R7: segment mode, type 001 does not end
        r0 = req_cnt; c0 = cmp_cnt;
        for (int i = 0; i < 3; i++) send_cell(4'd4, 3'b001);
        idle(10);
        chk(req_cnt - r0 == 1, "R7", "segment mode one request", 32'(req_cnt - r0), 1);
        chk(cmp_cnt == c0, "R7", "segment mode no completion", 32'(cmp_cnt - c0), 0);
        chk(cell_ready == 1'b1, "R7", "segment mode still accepting", 32'(cell_ready), 1);

        // R4: channel off
        r0 = req_cnt; c0 = cmp_cnt;
        send_cell(4'd5, 3'b001); send_cell(4'd5, 3'b011);
        idle(10);
        chk(req_cnt == r0, "R4", "off channel no request", 32'(req_cnt - r0), 0);
        chk(cmp_cnt == c0, "R4", "off channel no completion", 32'(cmp_cnt - c0), 0);
        chk(cell_ready == 1'b1, "R4", "off channel ready", 32'(cell_ready), 1);

        // R11: static change inside a packet
        next_addr = 28'h0400000; r0 = req_cnt; c0 = cmp_cnt;
        send_cell(4'd6, 3'b000);
        cfg(4'd6, 9'h000);
        send_cell(4'd6, 3'b001);
        wait_cmp(c0 + 1, got);
        chk(got && cap_len == 11'd96, "R11", "open packet uses old copy", 32'(cap_len), 96);
        r0 = req_cnt; c0 = cmp_cnt;
        send_cell(4'd6, 3'b001);
        idle(10);
        chk(req_cnt == r0 && cmp_cnt == c0, "R11", "next packet follows new field",
            32'(req_cnt - r0), 0);

        // R1: reset in mid-packet clears activity
        next_addr = 28'h0500000;
        send_cell(4'd7, 3'b000);
        idle(2);
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cell_ready == 1'b1 && !buf_req && !cmp_valid, "R1", "state after second reset",
            32'({cell_ready, buf_req, cmp_valid}), 32'h4);
        cfg(4'd7, 9'h080);
        r0 = req_cnt; c0 = cmp_cnt; next_addr = 28'h0600000;
        send_cell(4'd7, 3'b001);
        wait_cmp(c0 + 1, got);
        chk(req_cnt - r0 == 1, "R1", "channel inactive after reset", 32'(req_cnt - r0), 1);
        chk(cap_len == 11'd48, "R1", "fresh length after reset", 32'(cap_len), 48);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL R2 watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule